// File: doc/BRIEF.md
# Serial Flash Continuous Read Engine

This block serves linear reads from a page-organised serial flash whose page size need not be a power of two. A requester hands over a start offset and a byte count, together with the page size, the page shift and the device size in bytes. The engine turns the linear offset into the flash's page/byte address: the page index is shifted left by the page shift, and the byte-within-page is added. It then frames a single continuous array read and streams every data byte back on a valid/ready output. When the transfer is over it reports how many data bytes were returned.

The engine sits between a request source and a byte-level serial link. The link's serializer is outside this block. Each byte the engine offers on the transmit side is exchanged for one byte that comes back on the receive side. Only one byte is in flight at a time. The command header is eight bytes long and is sent under the same chip-select assertion as the data bytes. Bytes that come back during the header are dropped.

The controller has eight states:
- `ST_IDLE` accepts a request.
- `ST_DIVIDE` waits on a restoring divider for the page index and the byte-in-page.
- `ST_HDR_TX` and `ST_HDR_RX` send each header byte and absorb its echo.
- `ST_DAT_TX`, `ST_DAT_RX` and `ST_DAT_OUT` send a fill byte, capture the returned data and hold it until it is taken.
- `ST_DONE` reports the result for one cycle.

Transitions:
- IDLE→DONE on an empty or rejected request, IDLE→DIVIDE otherwise.
- DIVIDE→HDR_TX when the quotient is ready.
- HDR_TX→HDR_RX on a link accept.
- HDR_RX→HDR_TX on an echo, or HDR_RX→DAT_TX on the eighth echo.
- DAT_TX→DAT_RX on a link accept.
- DAT_RX→DAT_OUT on a returned byte.
- DAT_OUT→DAT_TX when more bytes remain, or DAT_OUT→DONE on the last handshake.
- DONE→IDLE.

Top module: `sfcr_engine`

## Requirements
- R1: A request with length zero completes with `done` high in the cycle after acceptance, `done_count` 0 and `done_err` 0, and `link_cs` is never asserted.
- R2: A non-zero request is rejected in either of two cases: offset plus length exceeds `cfg_dev_size`, or `cfg_page_size` is zero. A rejected request completes one cycle after acceptance with `done_err` 1, `done_count` 0 and no link activity. An end equal to the device size is accepted.
- R3: The 24-bit flash address is ((offset / page_size) << page_shift) + (offset % page_size), truncated to 24 bits.
- R4: The header is sent in this order: byte 0 is opcode 0xE8, then address bits 23:16, 15:8 and 7:0, then four fill bytes of value 0x00. That is eight header bytes.
- R5: The eight bytes received during the header are never forwarded to `dout`. The first output byte is the byte received for the ninth link transfer.
- R6: After the header, exactly `req_len` further link transfers are made, each sending 0x00. `link_cs` stays high from the first header byte to the last data byte, with no new command at a page boundary. It falls only as the engine enters `ST_DONE`.
- R7: On a successful completion, `done_count` equals the total number of link transfers minus 8, which is the requested length.
- R8: `link_tx_valid` and `dout_valid` hold high with stable data until accepted, and at most one link byte is outstanding.
- R9: `req_ready` is high only in `ST_IDLE`. `link_cs` is low whenever `req_ready` is high, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_ofs | input | OFS_W | Linear start offset in bytes |
| req_len | input | OFS_W | Number of data bytes to read |
| cfg_page_size | input | PS_W | Bytes per flash page |
| cfg_page_shift | input | SH_W | Left shift applied to the page index |
| cfg_dev_size | input | OFS_W+1 | Device capacity in bytes |
| link_cs | output | 1 | Chip select, high for the whole command |
| link_tx_valid | output | 1 | Byte offered to the serializer |
| link_tx_ready | input | 1 | Serializer accepts the offered byte |
| link_tx_data | output | 8 | Byte to shift out |
| link_rx_valid | input | 1 | Byte shifted in is available (one cycle) |
| link_rx_data | input | 8 | Byte shifted in |
| dout_valid | output | 1 | Data byte available |
| dout_ready | input | 1 | Consumer takes the data byte |
| dout_data | output | 8 | Data byte |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion was a rejection |
| done_count | output | OFS_W | Data bytes returned, valid with done |

## Verification
A wrong quotient or remainder from the divider would first show in header bytes 1 to 3. The returned data would then come from the wrong linear position, and the stream checks would catch that from the first output byte. A header counter that is off by one would either forward an echo byte or emit a ninth header byte. That shows at once in the first `dout` byte, in the transmit log, and later as a count or length mismatch at `done`. An error in the range check or the zero-length path shows in the completion cycle as a wrong `done_err` or `done_count`, or as `link_cs` rising when it should not.

// File: rtl/sfcr_pkg.sv
package sfcr_pkg;
    localparam int        HDR_LEN = 8;
    localparam int        ADDR_W  = 24;
    localparam logic [7:0] RD_OP  = 8'hE8;
    localparam logic [7:0] FILL   = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_HDR_TX,
        ST_HDR_RX,
        ST_DAT_TX,
        ST_DAT_RX,
        ST_DAT_OUT,
        ST_DONE
    } state_t;
endpackage

// File: rtl/sfcr_divider.sv
module sfcr_divider #(
    parameter int W    = 24,
    parameter int PS_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [W-1:0]    dividend,
    input  logic [PS_W-1:0] divisor,
    output logic            fin,
    output logic [W-1:0]    quot,
    output logic [PS_W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]    q_q;
    logic [PS_W-1:0] rem_q;
    logic [PS_W-1:0] dvs_q;
    logic [CW-1:0]   steps_q;
    logic            busy_q;
    logic            fin_q;
    logic [PS_W:0]   trial;
    logic            ge;

    assign trial = {rem_q, q_q[W-1]};
    assign ge    = trial >= {1'b0, dvs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q     <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            steps_q <= '0;
            busy_q  <= 1'b0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                q_q     <= dividend;
                rem_q   <= '0;
                dvs_q   <= divisor;
                steps_q <= CW'(W);
                busy_q  <= 1'b1;
            end else if (busy_q) begin
                rem_q   <= PS_W'(ge ? trial - {1'b0, dvs_q} : trial);
                q_q     <= {q_q[W-2:0], ge};
                steps_q <= steps_q - 1'b1;
                if (steps_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    fin_q  <= 1'b1;
                end
            end
        end
    end

    assign fin  = fin_q;
    assign quot = q_q;
    assign rem  = rem_q;

    // R3
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rem < dvs_q));
endmodule

// File: rtl/sfcr_hdr_sel.sv
module sfcr_hdr_sel
    import sfcr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        idx,
    output logic [7:0]        hdr_byte
);
    always_comb begin
        unique case (idx)
            3'd0:    hdr_byte = RD_OP;
            3'd1:    hdr_byte = addr[23:16];
            3'd2:    hdr_byte = addr[15:8];
            3'd3:    hdr_byte = addr[7:0];
            default: hdr_byte = FILL;
        endcase
    end
endmodule

// File: rtl/sfcr_counter.sv
module sfcr_counter #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sfcr_engine.sv
module sfcr_engine
    import sfcr_pkg::*;
#(
    parameter int OFS_W = 24,
    parameter int PS_W  = 12,
    parameter int SH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic [OFS_W-1:0] req_len,
    input  logic [PS_W-1:0]  cfg_page_size,
    input  logic [SH_W-1:0]  cfg_page_shift,
    input  logic [OFS_W:0]   cfg_dev_size,
    output logic             link_cs,
    output logic             link_tx_valid,
    input  logic             link_tx_ready,
    output logic [7:0]       link_tx_data,
    input  logic             link_rx_valid,
    input  logic [7:0]       link_rx_data,
    output logic             dout_valid,
    input  logic             dout_ready,
    output logic [7:0]       dout_data,
    output logic             done,
    output logic             done_err,
    output logic [OFS_W-1:0] done_count
);
    localparam int CNT_W = OFS_W + 1;

    state_t            state_q, state_d;
    logic [OFS_W-1:0]  len_q, left_q;
    logic [SH_W-1:0]   shift_q;
    logic              err_q, ran_q;
    logic [3:0]        hdr_idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic              bad_req, empty_req, div_start, div_fin;
    logic [OFS_W-1:0]  div_quot;
    logic [PS_W-1:0]   div_rem;
    logic [7:0]        hdr_byte;
    logic [CNT_W-1:0]  xfer_cnt;
    logic              xfer_inc;

    assign empty_req = (req_len == '0);
    assign bad_req   = (cfg_page_size == '0) ||
                       (({1'b0, req_ofs} + {1'b0, req_len}) > cfg_dev_size);
    assign div_start = (state_q == ST_IDLE) && req_valid && !empty_req && !bad_req;
    assign xfer_inc  = link_rx_valid && ((state_q == ST_HDR_RX) || (state_q == ST_DAT_RX));

    sfcr_divider #(.W(OFS_W), .PS_W(PS_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .dividend(req_ofs), .divisor(cfg_page_size),
        .fin(div_fin), .quot(div_quot), .rem(div_rem)
    );

    sfcr_hdr_sel u_hdr (
        .addr(addr_q), .idx(hdr_idx_q[2:0]), .hdr_byte(hdr_byte)
    );

    sfcr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(state_q == ST_IDLE),
        .inc(xfer_inc), .cnt(xfer_cnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = (empty_req || bad_req) ? ST_DONE : ST_DIVIDE;
            ST_DIVIDE:  if (div_fin) state_d = ST_HDR_TX;
            ST_HDR_TX:  if (link_tx_ready) state_d = ST_HDR_RX;
            ST_HDR_RX:  if (link_rx_valid)
                            state_d = (hdr_idx_q == 4'(HDR_LEN - 1)) ? ST_DAT_TX : ST_HDR_TX;
            ST_DAT_TX:  if (link_tx_ready) state_d = ST_DAT_RX;
            ST_DAT_RX:  if (link_rx_valid) state_d = ST_DAT_OUT;
            ST_DAT_OUT: if (dout_ready) state_d = (left_q == OFS_W'(1)) ? ST_DONE : ST_DAT_TX;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= '0;
            left_q    <= '0;
            shift_q   <= '0;
            err_q     <= 1'b0;
            ran_q     <= 1'b0;
            hdr_idx_q <= '0;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    len_q     <= empty_req ? '0 : (bad_req ? '0 : req_len);
                    left_q    <= req_len;
                    shift_q   <= cfg_page_shift;
                    err_q     <= !empty_req && bad_req;
                    ran_q     <= div_start;
                    hdr_idx_q <= '0;
                end
                ST_DIVIDE: if (div_fin)
                    addr_q <= ADDR_W'((ADDR_W'(div_quot) << shift_q) + ADDR_W'(div_rem));
                ST_HDR_RX: if (link_rx_valid) hdr_idx_q <= hdr_idx_q + 1'b1;
                ST_DAT_RX: if (link_rx_valid) data_q <= link_rx_data;
                ST_DAT_OUT: if (dout_ready) left_q <= left_q - 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        link_cs       = 1'b0;
        link_tx_valid = 1'b0;
        link_tx_data  = FILL;
        dout_valid    = 1'b0;
        done          = 1'b0;
        done_err      = 1'b0;
        done_count    = '0;
        unique case (state_q)
            ST_HDR_TX: begin
                link_cs       = 1'b1;
                link_tx_valid = 1'b1;
                link_tx_data  = hdr_byte;
            end
            ST_HDR_RX, ST_DAT_RX: link_cs = 1'b1;
            ST_DAT_TX: begin
                link_cs       = 1'b1;
                link_tx_valid = 1'b1;
            end
            ST_DAT_OUT: begin
                link_cs    = 1'b1;
                dout_valid = 1'b1;
            end
            ST_DONE: begin
                done       = 1'b1;
                done_err   = err_q;
                done_count = ran_q ? OFS_W'(xfer_cnt - CNT_W'(HDR_LEN)) : '0;
            end
            default: ;
        endcase
    end
    assign dout_data = data_q;

    // R5
    no_echo_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> (hdr_idx_q == 4'(HDR_LEN)));
    // R6
    cs_drop_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_cs) |-> done);
    // R7
    count_matches_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_err) |-> (done_count == len_q));
    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_tx_valid && !link_tx_ready) |=> (link_tx_valid && $stable(link_tx_data)));
    // R8
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data)));
    // R2
    reject_no_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> $past(req_ready));
endmodule

// File: tb/sfcr_engine_bench.sv
module sfcr_engine_bench;
    localparam int OFS_W = 24;
    localparam int PS_W  = 12;
    localparam int SH_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             req_valid = 1'b0, req_ready;
    logic [OFS_W-1:0] req_ofs = '0, req_len = '0;
    logic [PS_W-1:0]  cfg_page_size = '0;
    logic [SH_W-1:0]  cfg_page_shift = '0;
    logic [OFS_W:0]   cfg_dev_size = '0;
    logic             link_cs, link_tx_valid, link_tx_ready, link_rx_valid;
    logic [7:0]       link_tx_data, link_rx_data;
    logic             dout_valid, dout_ready;
    logic [7:0]       dout_data;
    logic             done, done_err;
    logic [OFS_W-1:0] done_count;

    sfcr_engine #(.OFS_W(OFS_W), .PS_W(PS_W), .SH_W(SH_W)) u_sfcr_engine (.*);

    int n_chk = 0, n_bad = 0;
    int tx_n, got_n, cs_rises, tick;
    logic [7:0] tx_log [0:63];
    logic [7:0] got [0:63];
    logic stall_out = 1'b0;
    int t_ps, t_sh;

    function automatic logic [7:0] pat(input int x);
        return 8'((x * 13) + (x >> 8));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // flash model on the byte link
    initial begin
        int pend, dly, cpage, cbyte;
        logic [7:0] pdata;
        logic [23:0] fa;
        logic cs_prev;
        pend = 0; dly = 0; cpage = 0; cbyte = 0; pdata = 0; fa = 0; cs_prev = 0;
        link_tx_ready = 1'b0; link_rx_valid = 1'b0; link_rx_data = 8'h00;
        forever begin
            @(negedge clk);
            tick++;
            link_tx_ready = 1'b0;
            link_rx_valid = 1'b0;
            if (link_cs && !cs_prev) cs_rises++;
            cs_prev = link_cs;
            if (pend != 0) begin
                if (dly == 0) begin
                    link_rx_valid = 1'b1;
                    link_rx_data  = pdata;
                    pend = 0;
                end else dly--;
            end else if (link_tx_valid && (tick % 3 != 1)) begin
                link_tx_ready = 1'b1;
                if (tx_n < 64) tx_log[tx_n] = link_tx_data;
                if (tx_n == 1) fa[23:16] = link_tx_data;
                if (tx_n == 2) fa[15:8]  = link_tx_data;
                if (tx_n == 3) begin
                    fa[7:0] = link_tx_data;
                    cpage = int'(fa >> t_sh);
                    cbyte = int'(fa & ((24'd1 << t_sh) - 1));
                end
                if (tx_n < 8) pdata = 8'hA5 ^ 8'(tx_n);
                else begin
                    pdata = pat(cpage * t_ps + cbyte);
                    cbyte++;
                    if (cbyte == t_ps) begin cbyte = 0; cpage++; end
                end
                tx_n++;
                pend = 1;
                dly  = tick % 2;
            end
        end
    end

    // stream consumer
    initial begin
        dout_ready = 1'b0;
        forever begin
            @(negedge clk);
            dout_ready = stall_out ? (tick % 4 == 0) : 1'b1;
            if (dout_valid && dout_ready) begin
                if (got_n < 64) got[got_n] = dout_data;
                got_n++;
            end
        end
    end

    task automatic run_read(input int ofs, input int len, input int ps, input int sh,
                            input int dev, input bit exp_err, input string tag);
        int wait_n;
        logic [23:0] exp_addr;
        bit ok;
        t_ps = ps; t_sh = sh;
        tx_n = 0; got_n = 0; cs_rises = 0;
        @(negedge clk);
        req_ofs = OFS_W'(ofs); req_len = OFS_W'(len);
        cfg_page_size = PS_W'(ps); cfg_page_shift = SH_W'(sh);
        cfg_dev_size = (OFS_W+1)'(dev);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 20000) begin @(negedge clk); wait_n++; end
        chk(done === 1'b1, {tag, " done seen"}, int'(done), 1);
        chk(done_err === exp_err, {tag, " err flag R2"}, int'(done_err), int'(exp_err));
        if (exp_err || len == 0) begin
            chk(done_count == 0, {tag, " count zero R1"}, int'(done_count), 0);
            chk(cs_rises == 0 && tx_n == 0, {tag, " no link R1"}, tx_n, 0);
            if (len == 0) chk(wait_n == 0, {tag, " immediate R1"}, wait_n, 0);
        end else begin
            exp_addr = 24'(((ofs / ps) << sh) + (ofs % ps));
            chk(tx_log[0] == 8'hE8, {tag, " opcode R4"}, int'(tx_log[0]), 'hE8);
            chk({tx_log[1], tx_log[2], tx_log[3]} == exp_addr, {tag, " address R3"},
                int'({tx_log[1], tx_log[2], tx_log[3]}), int'(exp_addr));
            ok = 1;
            for (int i = 4; i < 8 + len && i < 64; i++) if (tx_log[i] != 8'h00) ok = 0;
            chk(ok, {tag, " fill bytes R4 R6"}, 0, 0);
            chk(tx_n == 8 + len, {tag, " transfers R6"}, tx_n, 8 + len);
            chk(cs_rises == 1, {tag, " single select R6"}, cs_rises, 1);
            chk(got_n == len, {tag, " stream length R5"}, got_n, len);
            ok = 1;
            for (int i = 0; i < len && i < 64; i++) if (got[i] != pat(ofs + i)) ok = 0;
            chk(ok, {tag, " stream data R5"}, int'(got[0]), int'(pat(ofs)));
            chk(done_count == OFS_W'(len), {tag, " count R7"}, int'(done_count), len);
        end
        @(negedge clk);
        chk(req_ready && !link_cs, {tag, " back idle R9"}, int'(link_cs), 0);
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1, "reset ready R9", int'(req_ready), 1);
        chk(link_cs === 1'b0, "reset cs R9", int'(link_cs), 0);
        chk(dout_valid === 1'b0, "reset dout R8", int'(dout_valid), 0);
        chk(link_tx_valid === 1'b0 && done === 1'b0, "reset link R8", int'(link_tx_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_read(0, 5, 264, 9, 1081344, 1'b0, "first page");
        run_read(260, 10, 264, 9, 1081344, 1'b0, "page cross");
        run_read(1000, 6, 256, 8, 1048576, 1'b0, "pow2 page");
        run_read(100000, 3, 528, 10, 2162688, 1'b0, "large offset");
        stall_out = 1'b1;
        run_read(520, 20, 264, 9, 1081344, 1'b0, "stalled stream R8");
        stall_out = 1'b0;
        run_read(300, 0, 264, 9, 1081344, 1'b0, "zero length R1");
        run_read(2040, 9, 264, 9, 2048, 1'b1, "past end R2");
        run_read(2040, 8, 264, 9, 2048, 1'b0, "end at size R2");
        run_read(10, 4, 0, 9, 2048, 1'b1, "zero page R2");
        run_read(5000, 0, 264, 9, 2048, 1'b0, "zero length out of range R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule